// File: doc/BRIEF.md
# PLL-Qualified Reset Synchronizer

This block derives one clean reset for each clock domain of a design whose clocks are produced by an on-chip PLL. Three conditions combine into a single raw reset request: an active-low external reset pin, a flag that says device configuration has finished, and the PLL lock flag. The request is held for an extra hold-off period after lock appears. This hold-off is counted on the reference clock and starts again from zero whenever the request is raised.

Each domain has its own chain of flip-flops. The qualified request sets every chain at once, with no clock needed. When the request clears, each chain shifts zeros in on its own domain clock. As a result, all logic in a domain leaves reset on the same rising edge of that domain's clock. If the PLL loses lock during operation, every domain reset is asserted again at once, because logic clocked during the unlock may have reached an illegal state.

Top module: `pll_rst_sync`

## Requirements
- R1: While `rst_pin_n` is 0, `init_done` is 0 or `pll_locked` is 0, every bit of `dom_rst` is in its asserted state. Assertion happens without waiting for any clock edge.
- R2: After all three conditions become true, no domain leaves reset until `HOLDOFF` rising edges of `ref_clk` have occurred (default 16).
- R3: Domain i leaves reset on the `SYNC_STAGES`-th rising edge of `dom_clk[i]` that follows the `HOLDOFF`-th `ref_clk` edge (default 2 stages).
- R4: A domain reset deasserts only at a rising edge of that domain's clock, while the clock is high.
- R5: A drop of lock during the hold-off period restarts the count, and the full `HOLDOFF` edges are counted again from the next time lock is seen.
- R6: While `init_done` is 0, all domain resets stay asserted no matter how long the other conditions hold.
- R7: With `ACTIVE_LOW` = 0 (the default), an asserted reset reads 1 and a released reset reads 0. With `ACTIVE_LOW` = 1, both levels are inverted.
- R8: Once released, a domain stays released for as long as all three conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the hold-off count runs on it |
| rst_pin_n | input | 1 | External reset, active low, asynchronous |
| init_done | input | 1 | High once device configuration has finished |
| pll_locked | input | 1 | PLL lock flag, high when locked |
| dom_clk | input | NUM_DOMAINS | One clock per domain |
| dom_rst | output | NUM_DOMAINS | One reset per domain; polarity set by ACTIVE_LOW |

## Verification
The assertions assume that the three condition inputs may change at any moment but never exactly on a domain clock edge. They also assume every domain clock keeps running while the block is out of reset. The stimulus drives every input change one nanosecond after a falling edge of the reference clock. The domain clocks are offset by half a nanosecond, so their rising edges never line up with an input change or a reference edge. A hold-off completion therefore always lands strictly between two domain edges, and the release cycle that is expected is unique.

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int NUM_DOMAINS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLDOFF     = 16,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input  logic                   ref_clk,
  input  logic                   rst_pin_n,
  input  logic                   init_done,
  input  logic                   pll_locked,
  input  logic [NUM_DOMAINS-1:0] dom_clk,
  output logic [NUM_DOMAINS-1:0] dom_rst
);

  localparam int CW = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLDOFF);

  if (SYNC_STAGES < 2) begin : g_bad_depth
    $error("SYNC_STAGES must be at least 2");
  end

  logic          raw_req;
  logic [CW-1:0] hold_cnt;
  logic          lock_ok;
  logic          req;

  assign raw_req = ~rst_pin_n | ~init_done | ~pll_locked;
  assign lock_ok = (hold_cnt == HOLD_END);
  assign req     = raw_req | ~lock_ok;

  always_ff @(posedge ref_clk or posedge raw_req) begin
    if (raw_req)       hold_cnt <= '0;
    else if (!lock_ok) hold_cnt <= hold_cnt + 1'b1;
  end

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge dom_clk[d] or posedge req) begin
      if (req) chain <= '1;
      else     chain <= {chain[SYNC_STAGES-2:0], 1'b0};
    end

    assign dom_rst[d] = chain[SYNC_STAGES-1] ^ ACTIVE_LOW;
  end

endmodule

// File: rtl/pll_rst_sync_chk.sv
module pll_rst_sync_chk #(
  parameter int NUM_DOMAINS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLDOFF     = 16,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input logic                   ref_clk,
  input logic                   rst_pin_n,
  input logic                   init_done,
  input logic                   pll_locked,
  input logic [NUM_DOMAINS-1:0] dom_clk,
  input logic [NUM_DOMAINS-1:0] dom_rst
);

  logic                   cond_bad;
  logic [NUM_DOMAINS-1:0] act;
  int                     seen;

  assign cond_bad = !(rst_pin_n === 1'b1 && init_done === 1'b1 && pll_locked === 1'b1);
  assign act      = dom_rst ^ {NUM_DOMAINS{ACTIVE_LOW}};

  always_ff @(posedge ref_clk or posedge cond_bad) begin
    if (cond_bad)           seen <= 0;
    else if (seen < HOLDOFF) seen <= seen + 1;
  end

  always @(negedge ref_clk) begin
    if (cond_bad) begin
      a_r1_cond_forces_reset: assert (&act)
        else $error("reset released while a condition is false");
    end else if (seen < HOLDOFF) begin
      a_r2_holdoff_not_done: assert (&act)
        else $error("reset released before hold-off expired");
    end
  end

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_chk
    always @(negedge act[d]) begin
      a_r4_release_on_edge: assert (dom_clk[d] === 1'b1)
        else $error("domain %0d released away from a clock edge", d);
    end

    a_r8_stays_released: assert property (@(posedge dom_clk[d]) disable iff (cond_bad)
      !act[d] |=> !act[d])
      else $error("domain %0d re-entered reset without cause", d);
  end

endmodule

bind pll_rst_sync pll_rst_sync_chk #(
  .NUM_DOMAINS(NUM_DOMAINS),
  .SYNC_STAGES(SYNC_STAGES),
  .HOLDOFF(HOLDOFF),
  .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
  .ref_clk(ref_clk),
  .rst_pin_n(rst_pin_n),
  .init_done(init_done),
  .pll_locked(pll_locked),
  .dom_clk(dom_clk),
  .dom_rst(dom_rst)
);

// File: tb/test_pll_rst_sync.sv
`timescale 1ns/1ps
module test_pll_rst_sync;

  localparam int ND = 3;
  localparam int SS = 2;
  localparam int HO = 16;
  localparam real H0 = 5.0, H1 = 3.0, H2 = 7.0;

  logic ref_clk = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic rst_pin_n, init_done, pll_locked;
  logic [ND-1:0] dom_clk;
  logic [ND-1:0] dom_rst;
  int checks = 0, failures = 0;
  realtime rel0 = -1.0, rel1 = -1.0, rel2 = -1.0;
  logic hi0, hi1, hi2;

  assign dom_clk = {c2, c1, c0};

  pll_rst_sync #(.NUM_DOMAINS(ND), .SYNC_STAGES(SS), .HOLDOFF(HO), .ACTIVE_LOW(1'b0)) i_pll_rst_sync (
    .ref_clk(ref_clk), .rst_pin_n(rst_pin_n), .init_done(init_done),
    .pll_locked(pll_locked), .dom_clk(dom_clk), .dom_rst(dom_rst)
  );

  always #4 ref_clk = ~ref_clk;
  initial begin #0.5; forever #H0 c0 = ~c0; end
  initial begin #0.5; forever #H1 c1 = ~c1; end
  initial begin #0.5; forever #H2 c2 = ~c2; end

  always @(negedge dom_rst[0]) begin rel0 = $realtime; hi0 = c0; end
  always @(negedge dom_rst[1]) begin rel1 = $realtime; hi1 = c1; end
  always @(negedge dom_rst[2]) begin rel2 = $realtime; hi2 = c2; end

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic drive_slot();
    @(negedge ref_clk);
    #1;
  endtask

  function automatic real exp_release(input real t_ok, input real h);
    real first;
    int k;
    first = 0.5 + h;
    if (t_ok < first) k = 0;
    else k = $rtoi($floor((t_ok - first) / (2.0 * h))) + 1;
    return first + 2.0 * h * (k + SS - 1);
  endfunction

  task automatic verify_release(input string req);
    realtime t_raw, t_ok;
    t_raw = $realtime;
    repeat (HO) @(posedge ref_clk);
    t_ok = $realtime;
    #0.1;
    check(dom_rst == 3'b111, "R2", "still in reset at hold-off end", dom_rst, 7);
    check(rel0 < t_raw && rel1 < t_raw && rel2 < t_raw, "R2", "no early release",
          (rel0 > rel1 ? rel0 : rel1), t_raw);
    #200;
    check(rel0 > t_ok && (rel0 - exp_release(t_ok, H0)) < 0.01 && (exp_release(t_ok, H0) - rel0) < 0.01,
          req, "domain0 release time (R3)", rel0, exp_release(t_ok, H0));
    check(rel1 > t_ok && (rel1 - exp_release(t_ok, H1)) < 0.01 && (exp_release(t_ok, H1) - rel1) < 0.01,
          req, "domain1 release time (R3)", rel1, exp_release(t_ok, H1));
    check(rel2 > t_ok && (rel2 - exp_release(t_ok, H2)) < 0.01 && (exp_release(t_ok, H2) - rel2) < 0.01,
          req, "domain2 release time (R3)", rel2, exp_release(t_ok, H2));
    check(hi0 && hi1 && hi2, "R4", "clock high at release", {hi2, hi1, hi0}, 7);
    check(dom_rst == 3'b000, "R7", "released level is 0", dom_rst, 0);
  endtask

  task automatic t_reset_state();
    repeat (5) drive_slot();
    check(dom_rst == 3'b111, "R1", "reset at power-up", dom_rst, 7);
    check(dom_rst[0] === 1'b1, "R7", "asserted level is 1", dom_rst[0], 1);
  endtask

  task automatic t_init_hold();
    drive_slot();
    rst_pin_n = 1'b1;
    pll_locked = 1'b1;
    repeat (40) drive_slot();
    check(dom_rst == 3'b111, "R6", "held while init not done", dom_rst, 7);
  endtask

  task automatic t_first_release();
    drive_slot();
    init_done = 1'b1;
    verify_release("R3");
    repeat (100) drive_slot();
    check(dom_rst == 3'b000, "R8", "stays released", dom_rst, 0);
  endtask

  task automatic t_lock_drop();
    drive_slot();
    pll_locked = 1'b0;
    #0.1;
    check(dom_rst == 3'b111, "R1", "immediate assert on lock loss", dom_rst, 7);
    repeat (5) drive_slot();
    pll_locked = 1'b1;
    repeat (10) @(posedge ref_clk);
    drive_slot();
    pll_locked = 1'b0;
    #0.1;
    check(dom_rst == 3'b111, "R5", "asserted during hold-off drop", dom_rst, 7);
    drive_slot();
    pll_locked = 1'b1;
    verify_release("R5");
  endtask

  task automatic t_pin_reset();
    drive_slot();
    rst_pin_n = 1'b0;
    #0.1;
    check(dom_rst == 3'b111, "R1", "immediate assert on pin", dom_rst, 7);
    repeat (3) drive_slot();
    rst_pin_n = 1'b1;
    verify_release("R3");
  endtask

  initial begin
    rst_pin_n = 1'b0;
    init_done = 1'b0;
    pll_locked = 1'b0;
    t_reset_state();
    t_init_hold();
    t_first_release();
    t_lock_drop();
    t_pin_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8.0 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule